// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a one- or two-dimensional memory transfer. Software sets up a start address, an inner (row) element count and signed step, and an outer (row-to-row) count and signed step through a small register port. It then launches the transfer with a control write. While running, the block holds a valid address. Each accepted handshake from the data mover moves the block on to the next address.

Steps are signed and scaled by a selectable element size, so the jump between rows may be smaller than the row span, or negative. This allows interleaved streams to be split or merged on the fly. At the end of every row and every buffer the block emits a one-cycle event pulse, and it can raise an interrupt pulse at either point. In stop mode the block halts with a done flag after the final element. In circular mode it rewinds to the start address and keeps running.

Registers: word 0 holds the start address. Word 1 holds the inner count in bits 15:0 and the inner step in bits 31:16. Word 2 has the same layout for the outer dimension. Word 3 is control, and a write to it is acted on at once and not stored. Its bits are: 0 enable, 1 two-dimensional, 2 circular, 4:3 element size, 5 row interrupt enable, 6 buffer interrupt enable.

Top module: `dma2d_agen`

## Requirements
- R1: After reset, out_valid, done, row_done, buf_done and irq are all 0.
- R2: A control write (cfg_addr 3) with bit 0 set while idle starts a transfer. In the next cycle out_valid is 1, done is 0 and out_addr equals the staged start address.
- R3: Within a row, each accepted handshake (out_valid and out_ready high at a clock edge) adds the sign-extended inner step times the element size to out_addr.
- R4: A handshake on the last element of a row adds the sign-extended outer step times the element size instead. row_done pulses for one cycle in the next cycle. On the last row, buf_done pulses together with it.
- R5: A count field of 0 means 65536 elements, and any other value means that many elements. With control bit 1 clear, the transfer is one-dimensional and the outer count is taken as 1 whatever was written.
- R6: Control bits 4:3 select the element size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R7: In stop mode (control bit 2 clear), the handshake on the final element ends the transfer. From the next cycle done is 1 and out_valid is 0. Further handshakes cause no events and no change until a new start.
- R8: In circular mode (control bit 2 set), the handshake on the final element reloads the start address and both counts. The transfer continues, and done stays 0.
- R9: irq pulses in the cycle after a row-end handshake when control bit 5 was set at start. It also pulses in the cycle after a buffer-end handshake when control bit 6 was set.
- R10: Writes to words 0 to 2, and control writes with bit 0 set, made during an active transfer do not change that transfer. Writes to words 0 to 2 take effect at the next start.
- R11: A control write with bit 0 clear during an active transfer stops it. In the next cycle out_valid is 0 and done stays 0.
- R12: While out_valid is 1 and out_ready is 0, out_addr holds its value and no event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| out_addr | output | 32 | Current transfer address |
| out_valid | output | 1 | Address valid (transfer active) |
| out_ready | input | 1 | Data mover accepts the current address |
| row_done | output | 1 | One-cycle pulse after the last element of a row |
| buf_done | output | 1 | One-cycle pulse after the last element of the buffer |
| irq | output | 1 | One-cycle interrupt pulse at enabled row/buffer ends |
| done | output | 1 | Stop-mode transfer finished |

## Verification
A wrong row or column index shows up on out_addr at the first handshake that crosses a row. It also moves the row_done pulse away from the element where the bench's closed-form model expects it, so a fault appears within one row of its cause. A wrong step scaling or sign corrupts the address one handshake after the faulty element. A faulty reload in circular mode is caught on the first address of the second pass. Staging errors appear only at the next start, which is why the bench restarts after changing registers in the middle of a transfer.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  parameter int ADDR_W = 32;
  parameter int CNT_W  = 16;
  parameter int STEP_W = 16;
  parameter int REG_W  = CNT_W + STEP_W;

  // control word bit positions (software visible)
  localparam int CTL_EN   = 0;
  localparam int CTL_2D   = 1;
  localparam int CTL_CIRC = 2;
  localparam int CTL_SZ   = 3;  // two bits
  localparam int CTL_RIE  = 5;
  localparam int CTL_BIE  = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  xcnt;
    logic [CNT_W-1:0]  ycnt;
    logic [STEP_W-1:0] xstep;
    logic [STEP_W-1:0] ystep;
    logic              two_d;
    logic              circ;
    logic [1:0]        esize;
    logic              row_ie;
    logic              buf_ie;
  } cfg_t;

  // sign-extend a step and scale it by the element size
  function automatic logic [ADDR_W-1:0] scale_step(input logic [STEP_W-1:0] st,
                                                   input logic [1:0] es);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-STEP_W){st[STEP_W-1]}}, st};
    case (es)
      2'd0:    return ext;
      2'd1:    return ext << 1;
      default: return ext << 2;
    endcase
  endfunction

  // index is the final one of a dimension; count 0 encodes 2**CNT_W
  function automatic logic idx_is_last(input logic [CNT_W-1:0] idx,
                                       input logic [CNT_W-1:0] cnt);
    return idx == CNT_W'(cnt - 1'b1);
  endfunction
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        waddr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              active,
  output cfg_t              work,
  output logic [ADDR_W-1:0] stage_base,
  output logic              start_p,
  output logic              stop_p
);
  logic [REG_W-1:0] stage_x, stage_y;
  logic             ctl_wr;

  assign ctl_wr  = we && (waddr == 2'd3);
  assign start_p = ctl_wr && wdata[CTL_EN] && !active;
  assign stop_p  = ctl_wr && !wdata[CTL_EN] && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_base <= '0;
      stage_x    <= '0;
      stage_y    <= '0;
      work       <= '0;
    end else begin
      if (we) begin
        case (waddr)
          2'd0:    stage_base <= wdata[ADDR_W-1:0];
          2'd1:    stage_x    <= wdata;
          2'd2:    stage_y    <= wdata;
          default: ;
        endcase
      end
      if (start_p) begin
        work.base   <= stage_base;
        work.xcnt   <= stage_x[CNT_W-1:0];
        work.xstep  <= stage_x[REG_W-1 -: STEP_W];
        work.ycnt   <= stage_y[CNT_W-1:0];
        work.ystep  <= stage_y[REG_W-1 -: STEP_W];
        work.two_d  <= wdata[CTL_2D];
        work.circ   <= wdata[CTL_CIRC];
        work.esize  <= wdata[CTL_SZ +: 2];
        work.row_ie <= wdata[CTL_RIE];
        work.buf_ie <= wdata[CTL_BIE];
      end
    end
  end
endmodule

// File: rtl/dma2d_dimcnt.sv
module dma2d_dimcnt
  import dma2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt,
  input  logic             force_last,
  output logic             last
);
  logic [CNT_W-1:0] idx;

  assign last = force_last || idx_is_last(idx, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= last ? '0 : CNT_W'(idx + 1'b1);
  end
endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              fire,
  input  logic              row_end,
  input  logic              buf_end,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] xstep_s,
  input  logic [ADDR_W-1:0] ystep_s,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (buf_end) addr <= base;
    else if (row_end) addr <= addr + ystep_s;
    else if (fire)    addr <= addr + xstep_s;
  end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              row_done,
  output logic              buf_done,
  output logic              irq,
  output logic              done
);
  cfg_t              work;
  logic [ADDR_W-1:0] stage_base;
  logic              start_p, stop_p;
  logic              active;
  logic              fire, x_last, y_last, row_end, buf_end;
  logic              work_circ;

  assign work_circ = work.circ;
  assign fire      = active && out_ready && !stop_p;
  assign row_end   = fire && x_last;
  assign buf_end   = row_end && y_last;
  assign out_valid = active;

  dma2d_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .active(active), .work(work), .stage_base(stage_base),
    .start_p(start_p), .stop_p(stop_p)
  );

  dma2d_dimcnt u_xcnt (
    .clk(clk), .rst_n(rst_n), .clr(start_p), .adv(fire),
    .cnt(work.xcnt), .force_last(1'b0), .last(x_last)
  );

  dma2d_dimcnt u_ycnt (
    .clk(clk), .rst_n(rst_n), .clr(start_p), .adv(row_end),
    .cnt(work.ycnt), .force_last(!work.two_d), .last(y_last)
  );

  dma2d_addr u_addr (
    .clk(clk), .rst_n(rst_n), .load(start_p), .load_val(stage_base),
    .fire(fire), .row_end(row_end), .buf_end(buf_end), .base(work.base),
    .xstep_s(scale_step(work.xstep, work.esize)),
    .ystep_s(scale_step(work.ystep, work.esize)),
    .addr(out_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done     <= 1'b0;
      row_done <= 1'b0;
      buf_done <= 1'b0;
      irq      <= 1'b0;
    end else begin
      row_done <= row_end;
      buf_done <= buf_end;
      irq      <= (row_end && work.row_ie) || (buf_end && work.buf_ie);
      if (stop_p) begin
        active <= 1'b0;
      end else if (start_p) begin
        active <= 1'b1;
        done   <= 1'b0;
      end else if (buf_end && !work.circ) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk
  import dma2d_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              row_done,
  input logic              buf_done,
  input logic              irq,
  input logic              done,
  input logic              work_circ,
  input logic              start_p,
  input logic              stop_p,
  input logic [ADDR_W-1:0] stage_base
);
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> out_valid && !done && out_addr == $past(stage_base));

  assert_buf_with_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> row_done);

  assert_event_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> $past(out_valid && out_ready));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_done_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_we) |=> done && !row_done);

  assert_circ_never_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !work_circ);

  assert_irq_at_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (row_done || buf_done));

  assert_stop_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !out_valid && !done);

  assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_we) |=> out_valid && $stable(out_addr) && !row_done);
endmodule

bind dma2d_agen dma2d_agen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .out_addr(out_addr),
  .out_valid(out_valid), .out_ready(out_ready), .row_done(row_done),
  .buf_done(buf_done), .irq(irq), .done(done), .work_circ(work_circ),
  .start_p(start_p), .stop_p(stop_p), .stage_base(stage_base)
);

// File: tb/dma2d_agen_test.sv
module dma2d_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] out_addr;
  logic        out_valid, out_ready = 1'b0;
  logic        row_done, buf_done, irq, done;

  int checks = 0;
  int failures = 0;
  bit p_row = 0, p_buf = 0, p_irq = 0;

  always #10 clk = ~clk;

  dma2d_agen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_addr(out_addr), .out_valid(out_valid),
    .out_ready(out_ready), .row_done(row_done), .buf_done(buf_done),
    .irq(irq), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pending events from the handshake of the previous cycle
  task automatic ev_check();
    chk(row_done === p_row, "R4 row_done", 32'(row_done), 32'(p_row));
    chk(buf_done === p_buf, "R4 buf_done", 32'(buf_done), 32'(p_buf));
    chk(irq === p_irq, "R9 irq", 32'(irq), 32'(p_irq));
    p_row = 0; p_buf = 0; p_irq = 0;
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] st, input int xc, input int xs,
                       input int yc, input int ys);
    wr(2'd0, st);
    wr(2'd1, {16'(xs), 16'(xc)});
    wr(2'd2, {16'(ys), 16'(yc)});
  endtask

  function automatic logic [31:0] ctl(input bit two_d, input bit circ,
                                      input logic [1:0] sz, input bit rie,
                                      input bit bie);
    return {25'd0, bie, rie, sz, circ, two_d, 1'b1};
  endfunction

  function automatic int esz(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // closed-form address of element (y, x)
  function automatic logic [31:0] exp_addr(input logic [31:0] st, input int xn,
                                           input int xs, input int ys, input int es,
                                           input int y, input int x);
    return st + 32'(es * (y * ((xn - 1) * xs + ys) + x * xs));
  endfunction

  task automatic walk(input int xn, input int yn, input int passes,
                      input logic [31:0] st, input int xs, input int ys,
                      input int es, input bit rie, input bit bie, input int pct,
                      input string tg);
    for (int p = 0; p < passes; p++)
      for (int y = 0; y < yn; y++)
        for (int x = 0; x < xn; x++) begin
          logic [31:0] e;
          bit lr, lb, r, stalled;
          e = exp_addr(st, xn, xs, ys, es, y, x);
          lr = (x == xn - 1);
          lb = lr && (y == yn - 1);
          stalled = 0;
          do begin
            ev_check();
            chk(out_valid === 1'b1 && out_addr === e,
                stalled ? "R12 stall addr" : (lr ? "R4 addr" : tg),
                out_addr, e);
            r = ($urandom % 100) < pct;
            out_ready = r;
            @(negedge clk);
            p_row = r && lr;
            p_buf = r && lb;
            p_irq = r && ((rie && lr) || (bie && lb));
            stalled = !r;
          end while (!r);
        end
  endtask

  task automatic finish_linear(input string tg);
    ev_check();
    out_ready = 1'b0;
    chk(done === 1'b1 && out_valid === 1'b0, tg, {30'd0, done, out_valid}, 32'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk({out_valid, done, row_done, buf_done, irq} === 5'd0, "R1 reset",
        {27'd0, out_valid, done, row_done, buf_done, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_valid, done, row_done, buf_done, irq} === 5'd0, "R1 after reset",
        {27'd0, out_valid, done, row_done, buf_done, irq}, 32'd0);

    // R5/R6: 1-D, outer count 7 ignored, 2-byte elements
    setup(32'h0000_1000, 5, 3, 7, 100);
    wr(2'd3, ctl(0, 0, 2'd1, 1, 0));
    chk(out_valid === 1'b1 && out_addr === 32'h1000, "R2 start", out_addr, 32'h1000);
    walk(5, 1, 1, 32'h1000, 3, 100, 2, 1, 0, 60, "R6 elem2");
    finish_linear("R5 one-d done");
    // R7: handshakes after completion are ignored
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid && done && !row_done && !buf_done && !irq, "R7 ignore",
          {27'd0, out_valid, done, row_done, buf_done, irq}, 32'h8);
    end
    out_ready = 1'b0;

    // R4: deinterleave, outer step negative, 1-byte elements
    setup(32'h0000_2000, 4, 3, 3, -8);
    wr(2'd3, ctl(1, 0, 2'd0, 1, 1));
    walk(4, 3, 1, 32'h2000, 3, -8, 1, 1, 1, 70, "R3 interleave");
    finish_linear("R7 done 2d");

    // R6: 4-byte elements with negative inner step
    setup(32'h0000_3000, 3, -1, 2, 5);
    wr(2'd3, ctl(1, 0, 2'd3, 0, 1));
    walk(3, 2, 1, 32'h3000, -1, 5, 4, 0, 1, 80, "R6 elem4");
    finish_linear("R7 done elem4");

    // R8/R9: circular, two passes with row and buffer interrupts, then R11 stop
    setup(32'h0000_4000, 3, 2, 2, 1);
    wr(2'd3, ctl(1, 1, 2'd0, 1, 1));
    walk(3, 2, 2, 32'h4000, 2, 1, 1, 1, 1, 70, "R8 circular");
    ev_check();
    out_ready = 1'b0;
    chk(out_valid === 1'b1 && out_addr === 32'h4000 && !done, "R8 reload",
        out_addr, 32'h4000);
    wr(2'd3, 32'd0);
    chk(!out_valid && !done, "R11 stop", {30'd0, out_valid, done}, 32'd0);

    // R10: register writes during an active transfer
    setup(32'h0000_5000, 3, 1, 1, 0);
    wr(2'd3, ctl(0, 0, 2'd0, 0, 0));
    wr(2'd0, 32'h0000_9000);
    wr(2'd1, {16'd2, 16'd5});
    wr(2'd3, ctl(0, 1, 2'd2, 1, 1));
    chk(out_valid === 1'b1 && out_addr === 32'h5000, "R10 unchanged", out_addr, 32'h5000);
    walk(3, 1, 1, 32'h5000, 1, 0, 1, 0, 0, 70, "R10 old run");
    finish_linear("R10 still linear");
    wr(2'd3, ctl(0, 0, 2'd0, 0, 0));
    walk(5, 1, 1, 32'h9000, 2, 0, 1, 0, 0, 70, "R10 new run");
    finish_linear("R10 new done");

    // R5: count field 0 means 65536
    setup(32'h0000_0100, 0, 1, 1, 0);
    wr(2'd3, ctl(0, 0, 2'd0, 0, 1));
    walk(65536, 1, 1, 32'h100, 1, 0, 1, 0, 1, 100, "R5 full count");
    finish_linear("R5 full done");

    // random transfers
    for (int t = 0; t < 25; t++) begin
      int xn, yn, xs, ys, ye;
      bit two_d, rie, bie;
      logic [1:0] sz;
      logic [31:0] st;
      xn = 1 + int'($urandom % 6);
      yn = 1 + int'($urandom % 5);
      xs = int'($urandom % 41) - 20;
      ys = int'($urandom % 41) - 20;
      two_d = 1'($urandom);
      rie = 1'($urandom);
      bie = 1'($urandom);
      sz = 2'($urandom % 4);
      st = $urandom;
      ye = two_d ? yn : 1;
      setup(st, xn, xs, yn, ys);
      wr(2'd3, ctl(two_d, 0, sz, rie, bie));
      walk(xn, ye, 1, st, xs, ys, esz(sz), rie, bie, 60, "R3 random");
      finish_linear("R7 random done");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule